// File: doc/BRIEF.md
# Per-Channel Playback and Capture Buffer

This block is a small word store attached to one data channel. It is used during timing calibration. In playback mode it drives a word onto the channel output on every tick. That word comes either from the stored contents or from a free-running linear ramp. In capture mode it records the channel input word on every tick. After one full pass through the store it stops, so a finished capture cannot be overwritten before software has read it.

Each board receives the same broadcast strobe. When the strobe arrives, the store pointer jumps to a fixed start position, the capture count is cleared and the ramp restarts at zero. Every board then begins its window on the same tick. A host read port reads the store by an offset from that start position. Offset 0 is therefore always the word taken on the synchronising tick, and reading one tick's worth of words is enough for one calibration step.

Top module: `tick_capture_buffer`

## Requirements
- R1: After reset `dout_o` is 0 and `host_valid_o` is 0. The pointer sits at the start position (parameter `START_POS`, default 8) with an empty capture count, so the first capture tick without any strobe lands at host offset 0.
- R2: On a tick (`tick_en_i`=1) with `mode_i`=3 (capture), `din_i` is written at the pointer and the pointer advances by one, wrapping modulo `DEPTH`.
- R3: Once `DEPTH` words have been captured since the last reset or accepted strobe, further capture ticks write nothing and do not move the pointer.
- R4: On a tick with `mode_i`=1 (stored playback), `dout_o` takes the word at the pointer one clock later and the pointer advances with wrap. Playback never stops.
- R5: On a tick with `mode_i`=2 (ramp playback), `dout_o` takes the ramp value one clock later and the ramp then increments, wrapping at 2^`DATA_W`.
- R6: `sync_i` acts only together with `tick_en_i`. On such a tick the pointer is set to `START_POS`, the capture count to 0 and the ramp to 0, and that same tick already works from these values. A strobe without a tick has no effect.
- R7: With `tick_en_i`=0 the output holds, nothing is written and no pointer or ramp moves.
- R8: `host_rd_i`=1 with offset A gives, one clock later, `host_valid_o`=1 and `host_rdata_o` = word at (`START_POS`+A) mod `DEPTH`. Without a read, `host_valid_o` is 0 in the next clock.
- R9: A host read of the same location that a capture tick writes in the same clock returns the old content.
- R10: On a tick with `mode_i`=0 (idle) or 3 (capture), `dout_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en_i | input | 1 | One-clock marker of a tick boundary |
| sync_i | input | 1 | Broadcast resynchronisation strobe |
| mode_i | input | 2 | 0 idle, 1 stored playback, 2 ramp playback, 3 capture |
| din_i | input | DATA_W | Channel input word |
| dout_o | output | DATA_W | Channel output word |
| host_rd_i | input | 1 | Host read request |
| host_addr_i | input | log2(DEPTH) | Read offset from the start position |
| host_rdata_o | output | DATA_W | Read data |
| host_valid_o | output | 1 | Read data valid |

## Verification
Two pairs of functions can fall in the same clock. The first pair is the strobe and a capture or playback tick: the bench asserts `sync_i` together with `tick_en_i` in every mode and expects that tick to use the start position or ramp value 0. The second pair is a host read and a capture write to one location: the bench reads offset 0 while a synchronised capture tick writes there, and expects the previous word. A behavioural model is compared against the ports on every clock. Strobes without ticks and ticks after a full pass are also mixed in, and their effect is judged through later playback and host reads.

// File: rtl/tcb_pkg.sv
// Shared types for the tick capture buffer.
package tcb_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE      = 2'd0,
        MODE_PLAY_MEM  = 2'd1,
        MODE_PLAY_RAMP = 2'd2,
        MODE_SPY       = 2'd3
    } tcb_mode_e;
endpackage

// File: rtl/tcb_store.sv
// Word store: one write port and two asynchronous read ports.
// Assumes DEPTH is a power of two. Contents are not reset. Callers
// register the read data, so a read sampled in the clock of a write
// sees the old word.
module tcb_store #(
    parameter int W     = 8,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_a_addr,
    output logic [W-1:0]  rd_a_data,
    input  logic [AW-1:0] rd_b_addr,
    output logic [W-1:0]  rd_b_data
);
    logic [W-1:0] mem [DEPTH];

    // Capture write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Playback and host reads.
    assign rd_a_data = mem[rd_a_addr];
    assign rd_b_data = mem[rd_b_addr];
endmodule

// File: rtl/tcb_ptr_ctrl.sv
// Pointer, capture count and ramp control.
// Everything moves only on tick clocks. An accepted strobe restarts
// the pointer, count and ramp, and that same tick already uses the
// restarted values. Assumes DEPTH is a power of two.
module tcb_ptr_ctrl
    import tcb_pkg::*;
#(
    parameter int W         = 8,
    parameter int DEPTH     = 256,
    parameter int START_POS = 8,
    localparam int AW       = $clog2(DEPTH),
    localparam int CW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          sync,
    input  tcb_mode_e     mode,
    output logic [AW-1:0] cur_ptr,
    output logic [W-1:0]  cur_ramp,
    output logic          wr_en
);
    localparam logic [AW-1:0] START_A = AW'(START_POS);
    localparam logic [CW-1:0] FULL_C  = CW'(DEPTH);

    logic [AW-1:0] ptr_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  ramp_q;
    logic          tick_sync;
    logic [CW-1:0] base_cnt;
    logic          adv;

    // Values this tick works from, after any accepted strobe.
    always_comb begin
        tick_sync = tick_en && sync;
        cur_ptr   = tick_sync ? START_A : ptr_q;
        base_cnt  = tick_sync ? '0 : cnt_q;
        cur_ramp  = tick_sync ? '0 : ramp_q;
        wr_en     = tick_en && (mode == MODE_SPY) && (base_cnt != FULL_C);
        adv       = wr_en || (tick_en && (mode == MODE_PLAY_MEM));
    end

    // State update for pointer, capture count and ramp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= START_A;
            cnt_q  <= '0;
            ramp_q <= '0;
        end else begin
            ptr_q  <= adv ? cur_ptr + AW'(1) : cur_ptr;
            cnt_q  <= wr_en ? base_cnt + CW'(1) : base_cnt;
            ramp_q <= (tick_en && mode == MODE_PLAY_RAMP) ? cur_ramp + W'(1) : cur_ramp;
        end
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(ptr_q) && $stable(ramp_q)); // R7
    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && sync) |=> (ptr_q == START_A || ptr_q == START_A + AW'(1))); // R6
    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !sync && mode == MODE_PLAY_RAMP) |=> ramp_q == $past(ramp_q) + W'(1)); // R5
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == FULL_C && !(tick_en && sync)) |=> cnt_q == FULL_C); // R3
endmodule

// File: rtl/tick_capture_buffer.sv
// Per-channel playback and capture buffer (top).
// Drives a stored word, a ramp or zero on each tick, records input
// words on capture ticks, and serves host reads by offset from the
// start position. Assumes tick_en_i is a one-clock pulse per tick and
// DEPTH is a power of two.
module tick_capture_buffer
    import tcb_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 256,
    parameter int START_POS = 8,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en_i,
    input  logic              sync_i,
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    input  logic              host_rd_i,
    input  logic [AW-1:0]     host_addr_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic              host_valid_o
);
    localparam logic [AW-1:0] START_A = AW'(START_POS);

    tcb_mode_e         mode;
    logic [AW-1:0]     cur_ptr;
    logic [DATA_W-1:0] cur_ramp;
    logic              wr_en;
    logic [DATA_W-1:0] play_word;
    logic [DATA_W-1:0] host_word;
    logic [AW-1:0]     host_phys;

    assign mode      = tcb_mode_e'(mode_i);
    assign host_phys = START_A + host_addr_i;

    tcb_ptr_ctrl #(.W(DATA_W), .DEPTH(DEPTH), .START_POS(START_POS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en_i),
        .sync     (sync_i),
        .mode     (mode),
        .cur_ptr  (cur_ptr),
        .cur_ramp (cur_ramp),
        .wr_en    (wr_en)
    );

    tcb_store #(.W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (cur_ptr),
        .wr_data   (din_i),
        .rd_a_addr (cur_ptr),
        .rd_a_data (play_word),
        .rd_b_addr (host_phys),
        .rd_b_data (host_word)
    );

    // Channel output register, updated only on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_o <= '0;
        end else if (tick_en_i) begin
            case (mode)
                MODE_PLAY_MEM:  dout_o <= play_word;
                MODE_PLAY_RAMP: dout_o <= cur_ramp;
                default:        dout_o <= '0;
            endcase
        end
    end

    // Host read: one clock of latency, old data on a same-clock write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_valid_o <= 1'b0;
            host_rdata_o <= '0;
        end else begin
            host_valid_o <= host_rd_i;
            if (host_rd_i) begin
                host_rdata_o <= host_word;
            end
        end
    end

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en_i && (mode_i == 2'd0 || mode_i == 2'd3)) |=> dout_o == '0); // R10
    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en_i |=> $stable(dout_o)); // R7
    AST_HOST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_i |=> !host_valid_o); // R8
endmodule

// File: tb/tick_capture_buffer_tb.sv
module tick_capture_buffer_tb;
    localparam int W  = 8;
    localparam int D  = 256;
    localparam int SP = 8;
    localparam int AW = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          tick = 1'b0, sync = 1'b0, hrd = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [W-1:0]  din = '0;
    logic [AW-1:0] haddr = '0;
    logic [W-1:0]  dout, hdata;
    logic          hval;

    tick_capture_buffer #(.DATA_W(W), .DEPTH(D), .START_POS(SP)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick), .sync_i(sync),
        .mode_i(mode), .din_i(din), .dout_o(dout), .host_rd_i(hrd),
        .host_addr_i(haddr), .host_rdata_o(hdata), .host_valid_o(hval));

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // Behavioural model state.
    int           m_ptr, m_cnt, m_ramp;
    logic [W-1:0] m_mem [D];
    bit           m_known [D];
    logic [W-1:0] m_dout, m_hd;
    bit           m_dk, m_hk, m_hv;
    string        dtag = "R1", htag = "R8", phase = "R8";

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_step();
        int a;
        if (!rst_n) begin
            m_ptr = SP; m_cnt = 0; m_ramp = 0;
            m_dout = '0; m_dk = 1; m_hv = 0; dtag = "R1";
            return;
        end
        m_hv = hrd;
        if (hrd) begin
            a = (SP + int'(haddr)) % D;
            m_hd = m_mem[a]; m_hk = m_known[a];
            htag = (tick && mode == 2'd3 && (sync ? SP : m_ptr) == a && (sync || m_cnt < D)) ? "R9" : phase;
        end
        if (!tick) begin
            dtag = "R7";
            return;
        end
        if (sync) begin
            m_ptr = SP; m_cnt = 0; m_ramp = 0;
        end
        case (mode)
            2'd1: begin
                m_dout = m_mem[m_ptr]; m_dk = m_known[m_ptr];
                m_ptr = (m_ptr + 1) % D; dtag = sync ? "R6" : "R4";
            end
            2'd2: begin
                m_dout = W'(m_ramp); m_dk = 1;
                m_ramp = (m_ramp + 1) % (1 << W); dtag = sync ? "R6" : "R5";
            end
            2'd3: begin
                m_dout = '0; m_dk = 1; dtag = "R10";
                if (m_cnt < D) begin
                    m_mem[m_ptr] = din; m_known[m_ptr] = 1;
                    m_ptr = (m_ptr + 1) % D; m_cnt++;
                end
            end
            default: begin
                m_dout = '0; m_dk = 1; dtag = "R10";
            end
        endcase
    endtask

    task automatic compare();
        if (m_dk) check(dtag, dout, m_dout);
        check("R8", W'(hval), W'(m_hv));
        if (m_hv && m_hk) check(htag, hdata, m_hd);
    endtask

    // One clock: drive at the falling edge, model at the rising edge,
    // compare at the next falling edge.
    task automatic cyc(bit t, bit s, logic [1:0] m, logic [W-1:0] d, bit r, logic [AW-1:0] a);
        tick = t; sync = s; mode = m; din = d; hrd = r; haddr = a;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    initial begin
        for (int i = 0; i < D; i++) m_known[i] = 0;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, '0, 0, '0);
        rst_n = 1'b1;
        // R1: reset outputs, and first capture without strobe lands at offset 0
        check("R1", dout, '0);
        check("R1", W'(hval), '0);
        phase = "R1";
        cyc(1, 0, 3, 8'hA5, 0, '0);
        cyc(0, 0, 0, '0, 1, '0);
        // R2, R3: synchronised capture past one full pass, strobes without tick
        phase = "R2";
        for (int i = 0; i < 300; i++)
            cyc(1, (i == 0), 3, W'(i * 7 + 3), 0, '0);
        cyc(0, 1, 3, 8'h55, 0, '0);
        for (int i = 0; i < 5; i++) cyc(1, 0, 3, 8'hEE, 0, '0);
        phase = "R3";
        for (int i = 0; i < D; i++) cyc(0, 0, 3, '0, 1, AW'(i));
        // R4, R6, R7: stored playback with gaps and idle strobes, wraps
        for (int i = 0; i < 400; i++)
            cyc((i % 3) != 2, (i == 0) || (i % 7 == 5 && (i % 3) == 2), 1, '0, 0, '0);
        // R5, R6: ramp playback, wrap and mid-run restart
        for (int i = 0; i < 300; i++) cyc(1, (i == 0) || (i == 280), 2, '0, 0, '0);
        for (int i = 0; i < 4; i++) cyc(0, 1, 2, '0, 0, '0);
        cyc(1, 0, 2, '0, 0, '0);
        // R9: host read of the word written in the same clock
        phase = "R8";
        for (int k = 0; k < 4; k++) begin
            cyc(1, 1, 3, W'(8'h10 + k), 1, '0);
            cyc(0, 0, 3, '0, 1, '0);
            cyc(1, 0, 3, W'(8'h20 + k), 1, 8'd1);
            cyc(0, 0, 3, '0, 1, 8'd1);
        end
        // R10: idle ticks with strobes, then playback of fresh capture
        for (int i = 0; i < 6; i++) cyc(1, i == 2, 0, 8'hFF, 0, '0);
        cyc(1, 1, 1, '0, 0, '0);
        cyc(1, 0, 1, '0, 0, '0);
        for (int i = 0; i < 2 * D; i++) cyc(0, 0, 0, '0, 1, AW'(i));
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: all requirements, actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule